// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block stands between a serial-memory slave protocol engine and a 4096 x 8 storage array. After the engine has received a write word address, it presents that address once. It then presents each data byte as it arrives. The bytes are collected in a 32-entry page latch, and each entry has its own dirty flag. Nothing reaches the array until the engine reports a STOP. A STOP that closes a write with at least one latched byte starts a self-timed commit. During the commit, every dirty entry is written into the array once, and a busy flag is held for a fixed number of clock cycles. The engine uses that flag to withhold acknowledges, which lets a bus master poll for completion.

The word address splits into a page number (the upper seven bits) and an in-page offset (the five low bits). Only the offset advances after each byte, so a long burst folds back onto the start of the same page. A later byte then replaces the latched value of an earlier one. When the write-protect input is high, the array is never written and busy is never raised. A START that arrives before the STOP abandons the latched page.

Top module: `page_commit_buffer`

## Requirements
- R1: A single byte latched after an address load is written to exactly that address once STOP has been seen, and to no other location.
- R2: Each accepted byte advances only the five-bit in-page offset, which wraps from 31 to 0. The page number (address bits 11..5) stays fixed, so a burst that starts at offset 30 writes offsets 30, 31, 0, 1, 2 of the same page.
- R3: When more than 32 bytes arrive before STOP, each later byte replaces the earlier byte at the same offset. Each location is committed once, holding the last value received for it.
- R4: `mem_we_o` is never high before the STOP that ends the write, and it is high only while `busy_o` is high.
- R5: A STOP that launches a commit raises `busy_o` on the clock edge that samples it. `busy_o` then stays high for exactly `COMMIT_CYCLES` cycles and drops by itself.
- R6: With `wp_i` high at STOP, no commit starts, `busy_o` stays low and the array is not written. `mem_we_o` is never high while `wp_i` is high.
- R7: Only offsets that received a byte are written, one write pulse per such offset. The other locations in the page keep their contents.
- R8: A START accepted before STOP clears all latched bytes, so a following STOP starts no commit.
- R9: A STOP with no byte latched since the last address load starts no commit.
- R10: While `busy_o` is high, address loads, data bytes and STARTs are ignored. They change neither the bytes being committed nor the state left behind: a STOP after the commit ends starts no new commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_i | input | 1 | Write protect; high blocks all array writes |
| addr_load_i | input | 1 | Strobe: load the word address of a new write |
| addr_i | input | 12 | Word address captured by `addr_load_i` |
| byte_valid_i | input | 1 | Strobe: one data byte received |
| byte_data_i | input | 8 | Data byte captured by `byte_valid_i` |
| start_i | input | 1 | Strobe: START seen on the bus |
| stop_i | input | 1 | Strobe: STOP seen on the bus |
| busy_o | output | 1 | Commit in progress; the engine withholds acknowledges |
| mem_we_o | output | 1 | Array write enable, one cycle per byte |
| mem_addr_o | output | 12 | Array write address |
| mem_wdata_o | output | 8 | Array write data |

## Verification
Strobes are driven on the falling clock edge and take effect at the next rising edge. Busy is therefore already visible at the first falling edge after the STOP pulse. It is counted once per falling edge, and the count must equal the commit length. Array writes fall in the first 32 busy cycles, one slot per cycle, and the bench captures them into its own array copy on the rising edge. Contents and write counts are compared only after busy has fallen. A blocked commit (write protect, discard, empty page or strobes during busy) is checked on the falling edge right after the STOP, and again after a wait longer than any commit.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/pcb_page_latch.sv
module pcb_page_latch #(
  parameter int ADDR_W = 12,
  parameter int OFS_W  = 5,
  parameter int DATA_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load_i,
  input  logic [ADDR_W-1:0]           load_addr_i,
  input  logic                        byte_i,
  input  logic [DATA_W-1:0]           data_i,
  input  logic                        clear_i,
  input  logic [OFS_W-1:0]            rd_idx_i,
  output logic [DATA_W-1:0]           rd_data_o,
  output logic [(1<<OFS_W)-1:0]       dirty_o,
  output logic [ADDR_W-OFS_W-1:0]     page_o
);
  localparam int PAGE_N = 1 << OFS_W;
  localparam int PAGE_W = ADDR_W - OFS_W;

  logic [OFS_W-1:0]  ofs_q, ofs_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic [PAGE_N-1:0] dirty_q, dirty_d;
  logic [DATA_W-1:0] lat_q [PAGE_N];

  always_comb begin
    ofs_d   = ofs_q;
    page_d  = page_q;
    dirty_d = dirty_q;
    if (clear_i) dirty_d = '0;
    if (load_i) begin
      ofs_d   = load_addr_i[OFS_W-1:0];
      page_d  = load_addr_i[ADDR_W-1:OFS_W];
      dirty_d = '0;
    end else if (byte_i) begin
      ofs_d          = ofs_q + 1'b1;
      dirty_d[ofs_q] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_q   <= '0;
      page_q  <= '0;
      dirty_q <= '0;
    end else begin
      ofs_q   <= ofs_d;
      page_q  <= page_d;
      dirty_q <= dirty_d;
    end
  end

  for (genvar g = 0; g < PAGE_N; g++) begin : g_slot
    logic slot_en;
    assign slot_en = byte_i && !load_i && (ofs_q == OFS_W'(g));
    always_ff @(posedge clk) begin
      if (slot_en) lat_q[g] <= data_i;
    end
  end

  assign rd_data_o = lat_q[rd_idx_i];
  assign dirty_o   = dirty_q;
  assign page_o    = page_q;

  // R2: a data byte never moves the page number
  a_r2_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_i && !load_i) |=> $stable(page_o));
endmodule

// File: rtl/pcb_commit_seq.sv
module pcb_commit_seq
  import pcb_pkg::*;
#(
  parameter int OFS_W         = 5,
  parameter int COMMIT_CYCLES = 1250000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_i,
  input  logic             wp_i,
  input  logic             any_dirty_i,
  output logic             busy_o,
  output logic             scan_vld_o,
  output logic [OFS_W-1:0] scan_idx_o,
  output logic             done_o
);
  localparam int PAGE_N = 1 << OFS_W;
  localparam int CNT_W  = $clog2(COMMIT_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(COMMIT_CYCLES - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      SEQ_IDLE: begin
        if (stop_i && any_dirty_i && !wp_i) begin
          state_d = SEQ_RUN;
          cnt_d   = '0;
        end
      end
      SEQ_RUN: begin
        if (cnt_q == LAST) begin
          state_d = SEQ_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy_o     = (state_q == SEQ_RUN);
  assign done_o     = busy_o && (cnt_q == LAST);
  assign scan_vld_o = busy_o && (cnt_q < CNT_W'(PAGE_N));
  assign scan_idx_o = cnt_q[OFS_W-1:0];

  // R5: busy holds until the timer's final cycle, then drops
  a_r5_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);
  a_r5_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);
  // R6: write protect prevents a launch
  a_r6_wp_no_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && wp_i) |=> !busy_o);
  // R9: an empty page never launches
  a_r9_empty_no_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !any_dirty_i) |=> !busy_o);
endmodule

// File: rtl/page_commit_buffer.sv
module page_commit_buffer #(
  parameter int ADDR_W        = 12,
  parameter int OFS_W         = 5,
  parameter int DATA_W        = 8,
  parameter int COMMIT_CYCLES = 1250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_i,
  input  logic              addr_load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_valid_i,
  input  logic [DATA_W-1:0] byte_data_i,
  input  logic              start_i,
  input  logic              stop_i,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  localparam int PAGE_N = 1 << OFS_W;
  localparam int PAGE_W = ADDR_W - OFS_W;

  logic              busy, done, scan_vld;
  logic [OFS_W-1:0]  scan_idx;
  logic [PAGE_N-1:0] dirty;
  logic [PAGE_W-1:0] page;
  logic [DATA_W-1:0] rd_data;
  logic              load_g, byte_g, clear;

  // strobes only act while no commit runs
  assign load_g = addr_load_i && !busy;
  assign byte_g = byte_valid_i && !busy;
  assign clear  = done || (!busy && (start_i || (stop_i && wp_i)));

  pcb_page_latch #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .DATA_W(DATA_W)) u_latch (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_g),
    .load_addr_i (addr_i),
    .byte_i      (byte_g),
    .data_i      (byte_data_i),
    .clear_i     (clear),
    .rd_idx_i    (scan_idx),
    .rd_data_o   (rd_data),
    .dirty_o     (dirty),
    .page_o      (page)
  );

  pcb_commit_seq #(.OFS_W(OFS_W), .COMMIT_CYCLES(COMMIT_CYCLES)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .stop_i      (stop_i),
    .wp_i        (wp_i),
    .any_dirty_i (|dirty),
    .busy_o      (busy),
    .scan_vld_o  (scan_vld),
    .scan_idx_o  (scan_idx),
    .done_o      (done)
  );

  assign busy_o      = busy;
  assign mem_we_o    = scan_vld && dirty[scan_idx] && !wp_i;
  assign mem_addr_o  = {page, scan_idx};
  assign mem_wdata_o = rd_data;

  // R4: array writes only inside a commit
  a_r4_we_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> busy_o);
  // R10: the latched set is frozen during a commit and empty afterwards
  a_r10_mask_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (busy_o ? $stable(dirty) : (dirty == '0)));
  // R8: an accepted START leaves nothing latched
  a_r8_start_discards: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && !byte_valid_i && !addr_load_i) |=> (dirty == '0));
endmodule

// File: tb/page_commit_buffer_test.sv
module page_commit_buffer_test;
  localparam int CC = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wp = 1'b0, ld = 1'b0, bv = 1'b0, st = 1'b0, sp = 1'b0;
  logic [11:0] addr = '0;
  logic [7:0]  bd = '0;
  logic        busy, we;
  logic [11:0] maddr;
  logic [7:0]  mdata;

  int nchk = 0, nfail = 0, cyc = 0, we_cnt = 0;
  logic [7:0] arr [4096];
  logic [7:0] expm [4096];
  int   sh_page = 0, sh_ptr = 0, exp_we = 0;
  logic [7:0] sh_dat [32];
  bit   sh_v [32];

  always #2 clk = ~clk;

  page_commit_buffer #(.COMMIT_CYCLES(CC)) uut (
    .clk(clk), .rst_n(rst_n), .wp_i(wp), .addr_load_i(ld), .addr_i(addr),
    .byte_valid_i(bv), .byte_data_i(bd), .start_i(st), .stop_i(sp),
    .busy_o(busy), .mem_we_o(we), .mem_addr_o(maddr), .mem_wdata_o(mdata));

  function automatic logic [7:0] pat(int i);
    return 8'(i * 7 + 3);
  endfunction

  // bench-side storage array fed by the write port
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4096; i++) arr[i] <= pat(i);
    end else if (we) begin
      arr[maddr] <= mdata;
      we_cnt <= we_cnt + 1;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      nfail++;
      $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(bit ok, string req, int act, int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic clr_shadow();
    for (int i = 0; i < 32; i++) sh_v[i] = 1'b0;
  endtask

  task automatic do_load(int a, bit track);
    @(negedge clk); ld = 1'b1; addr = 12'(a);
    @(negedge clk); ld = 1'b0;
    if (track) begin sh_page = a >> 5; sh_ptr = a & 31; clr_shadow(); end
  endtask

  task automatic do_byte(logic [7:0] d, bit track);
    @(negedge clk); bv = 1'b1; bd = d;
    @(negedge clk); bv = 1'b0;
    if (track) begin sh_dat[sh_ptr] = d; sh_v[sh_ptr] = 1'b1; sh_ptr = (sh_ptr + 1) & 31; end
  endtask

  task automatic do_start(bit track);
    @(negedge clk); st = 1'b1;
    @(negedge clk); st = 1'b0;
    if (track) clr_shadow();
  endtask

  task automatic do_stop(bit track);
    int n;
    n = 0;
    if (track && !wp) begin
      for (int i = 0; i < 32; i++)
        if (sh_v[i]) begin expm[sh_page*32 + i] = sh_dat[i]; n++; end
    end
    if (track) begin exp_we = we_cnt + n; clr_shadow(); end
    @(negedge clk); sp = 1'b1;
    @(negedge clk); sp = 1'b0;
  endtask

  task automatic wait_commit(string req);
    int n;
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk(n == CC, req, n, CC);
  endtask

  task automatic cmp_mem(string req);
    int bad;
    bad = 0;
    for (int i = 0; i < 4096; i++) if (arr[i] !== expm[i]) bad++;
    chk(bad == 0, req, bad, 0);
    chk(we_cnt == exp_we, req, we_cnt, exp_we);
  endtask

  task automatic t_reset();
    chk(busy == 1'b0, "R5 reset busy", busy, 0);
    chk(we == 1'b0, "R4 reset we", we, 0);
  endtask

  task automatic t_single();
    do_load(12'h123, 1);
    do_byte(8'hA5, 1);
    repeat (3) @(negedge clk);
    chk(we_cnt == 0 && busy == 1'b0, "R4 no write before STOP", we_cnt, 0);
    do_stop(1);
    chk(busy == 1'b1, "R5 busy after STOP", busy, 1);
    wait_commit("R5 busy length");
    cmp_mem("R1 single byte");
  endtask

  task automatic t_wrap();
    do_load(12'h7DE, 1);
    for (int k = 0; k < 5; k++) do_byte(8'(8'hC0 + k), 1);
    do_stop(1);
    wait_commit("R5 busy length wrap");
    cmp_mem("R2 offset wrap");
    chk(arr[12'h7C1] == 8'hC3, "R2 offset 1 same page", arr[12'h7C1], 8'hC3);
  endtask

  task automatic t_overrun();
    do_load(12'h400, 1);
    for (int k = 0; k < 34; k++) do_byte(8'(8'h10 + k), 1);
    do_stop(1);
    wait_commit("R5 busy length overrun");
    cmp_mem("R3 overrun");
    chk(arr[12'h400] == 8'h30, "R3 offset 0 overwritten", arr[12'h400], 8'h30);
  endtask

  task automatic t_sparse();
    do_load(12'h2A5, 1);
    for (int k = 0; k < 3; k++) do_byte(8'(8'h60 + k), 1);
    do_stop(1);
    wait_commit("R5 busy length sparse");
    cmp_mem("R7 only received offsets");
  endtask

  task automatic t_wp();
    wp = 1'b1;
    do_load(12'h050, 1);
    do_byte(8'h11, 1);
    do_byte(8'h22, 1);
    do_stop(1);
    chk(busy == 1'b0, "R6 no busy under protect", busy, 0);
    for (int k = 0; k < CC + 10; k++) begin
      @(negedge clk);
      if (busy || we) chk(1'b0, "R6 busy/we under protect", 1, 0);
    end
    cmp_mem("R6 array untouched");
    wp = 1'b0;
  endtask

  task automatic t_discard();
    do_load(12'h300, 1);
    for (int k = 0; k < 3; k++) do_byte(8'(8'h70 + k), 1);
    do_start(1);
    do_stop(1);
    chk(busy == 1'b0, "R8 START discards", busy, 0);
    repeat (CC + 5) @(negedge clk);
    cmp_mem("R8 array untouched");
  endtask

  task automatic t_empty();
    do_load(12'h600, 1);
    do_stop(1);
    chk(busy == 1'b0, "R9 empty STOP", busy, 0);
    repeat (CC + 5) @(negedge clk);
    cmp_mem("R9 array untouched");
  endtask

  task automatic t_busy_ignore();
    do_load(12'h900, 1);
    do_byte(8'h5C, 1);
    do_byte(8'h5D, 1);
    do_stop(1);
    do_load(12'hA00, 0);
    for (int k = 0; k < 3; k++) do_byte(8'hEE, 0);
    do_start(0);
    while (busy) @(negedge clk);
    cmp_mem("R10 strobes during busy");
    do_stop(0);
    chk(busy == 1'b0, "R10 nothing left latched", busy, 0);
    repeat (CC + 5) @(negedge clk);
    cmp_mem("R10 no second commit");
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) expm[i] = pat(i);
    clr_shadow();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_wrap();
    t_overrun();
    t_sparse();
    t_wp();
    t_discard();
    t_empty();
    t_busy_ignore();
    summary();
    $finish;
  end
endmodule